// File: doc/BRIEF.md
# Five-Channel Buffered Down-Counter Bank

The block holds five down-counters behind a small word-addressed register file. Each channel has a count buffer that software fills. A counter takes the buffer value only on a manual load or an automatic reload, never on a buffer write, so software can stage the next period while the current one is still counting. Channels 0 to 3 also hold a compare buffer and an output-inversion select. These are stored and presented for a downstream waveform stage, which is not part of this block. Two configuration words are stored for a separate prescaler stage and driven out unchanged.

All five channels share one control word. Software writes the whole word at once. For each channel, the block compares the new value with the stored value and reacts only to a change of the start bit or a rise of the manual-load bit. Each channel decrements once per cycle in which its tick enable is high and its start bit is set. A tick that arrives while the counter holds zero is an expiry. On an expiry the channel raises a one-cycle event for the interrupt stage. It then either reloads from its buffer or stops. When it stops, the hardware clears its start bit, and software can read that change back.

Top module: `reload_timer_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration word, the control word, all buffers and all counters read 0, and no expiry event is raised.
- R2: Byte offsets are: 0x00 prescaler word, 0x04 divider word, 0x08 control word. For channel n in 0..3, the count buffer is at 0x0C+0x0C*n, the compare buffer at 0x10+0x0C*n, and the live counter readback at 0x14+0x0C*n. The configuration words, control word and buffers read back what was written. The control word keeps only bits 0-3 and 8-22, so writing all ones reads back 0x007FFF0F.
- R3: In the control word, the field of channel n starts at bit 0 for n=0 and at bit 4n+4 for n>=1. Within a field the bits are start (+0), manual load (+1), invert (+2) and auto-reload (+3). The invert bits of channels 0..3 drive inv_sel[n].
- R4: A 0-to-1 change of a channel's manual-load bit, measured against the stored control word, copies the count buffer into the counter. A control write in which that bit was already 1 leaves the counter unchanged.
- R5: A 0-to-1 change of the start bit makes the channel count from its current value. A 1-to-0 change stops it. While stopped, ticks leave the counter unchanged.
- R6: A running channel decrements by exactly one for each clock edge at which its tick enable is high. Each channel counts independently, and the readback offset returns the live counter value.
- R7: A tick at a clock edge where the running counter holds 0 is an expiry. expire_evt[n] is high for exactly the cycle after that edge.
- R8: On an expiry with auto-reload set, the counter takes the count buffer value and keeps running. Without auto-reload, the counter stays at 0 and the channel's start bit reads back 0.
- R9: Channel 4 has its count buffer at 0x3C and its readback at 0x40. Its field is start bit 20, manual load bit 21 and auto-reload bit 22. It has no invert bit and no compare buffer.
- R10: Offsets outside the map, including any offset whose two low bits are not 0 and offset 0x44 and above, read 0, and writes to them change no register.
- R11: If the manual-load and start bits rise in the same write, the loaded value is visible after that write before any decrement, even when the tick enable is already high.
- R12: presc_cfg and div_cfg always equal the stored prescaler and divider words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| tick_en | input | 5 | Per-channel count enable |
| expire_evt | output | 5 | One-cycle expiry event per channel |
| inv_sel | output | 4 | Output-inversion select, channels 0..3 |
| presc_cfg | output | DATA_W (32) | Stored prescaler word |
| div_cfg | output | DATA_W (32) | Stored divider word |

## Verification
The hardest case to reach is the first tick of a channel whose manual-load and start bits rise in the same write while its tick enable is already high. The bench holds the tick high before the write and reads the counter right after the write edge, so any decrement applied ahead of the load shows up as an off-by-one. The self-clearing of the start bit is reached the same way: the tick is held across the zero-count edge, and the bench samples both the event and the control word in the cycle after it.

// File: rtl/rtb_pkg.sv
// Shared constants, register selector type and control-word layout helpers
// for the buffered down-counter bank. Assumes a fixed channel count of five,
// with the last channel lacking an inverter bit.
package rtb_pkg;

    localparam int NUM_CH   = 5;
    localparam int CMP_CH   = NUM_CH - 1;
    localparam int CH_IDX_W = $clog2(NUM_CH);

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRESC,
        RK_DIV,
        RK_CTL,
        RK_CNTBUF,
        RK_CMPBUF,
        RK_LIVE
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t             kind;
        logic [CH_IDX_W-1:0]   ch;
    } reg_sel_t;

    // Lowest control bit of channel n's field.
    function automatic int unsigned fld_base(int unsigned n);
        return (n == 0) ? 0 : 4 * n + 4;
    endfunction

    function automatic bit has_inv(int unsigned n);
        return n != NUM_CH - 1;
    endfunction

    function automatic int unsigned start_pos(int unsigned n);
        return fld_base(n);
    endfunction

    function automatic int unsigned load_pos(int unsigned n);
        return fld_base(n) + 1;
    endfunction

    function automatic int unsigned inv_pos(int unsigned n);
        return fld_base(n) + 2;
    endfunction

    // Without an inverter bit the auto-reload bit moves down one place.
    function automatic int unsigned rld_pos(int unsigned n);
        return has_inv(n) ? fld_base(n) + 3 : fld_base(n) + 2;
    endfunction

    // Mask of all implemented control bits.
    function automatic logic [31:0] ctl_mask();
        logic [31:0] m;
        m = '0;
        for (int unsigned n = 0; n < NUM_CH; n++) begin
            m[start_pos(n)] = 1'b1;
            m[load_pos(n)]  = 1'b1;
            m[rld_pos(n)]   = 1'b1;
            if (has_inv(n)) m[inv_pos(n)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rtb_addr_dec.sv
// Address decoder: turns a byte offset into a register kind and channel.
// Assumes word-aligned accesses; any offset with nonzero low bits, or one
// outside the map, decodes to RK_NONE.
module rtb_addr_dec
    import rtb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int WW = ADDR_W - 2;

    logic [WW-1:0] word;
    assign word = addr[ADDR_W-1:2];

    // Map the word index onto a register kind and channel number.
    always_comb begin
        sel.kind = RK_NONE;
        sel.ch   = '0;
        if (addr[1:0] == 2'b00) begin
            if (word == WW'(0)) sel.kind = RK_PRESC;
            if (word == WW'(1)) sel.kind = RK_DIV;
            if (word == WW'(2)) sel.kind = RK_CTL;
            for (int n = 0; n < CMP_CH; n++) begin
                if (word == WW'(3 + 3 * n)) begin
                    sel.kind = RK_CNTBUF;
                    sel.ch   = CH_IDX_W'(n);
                end
                if (word == WW'(4 + 3 * n)) begin
                    sel.kind = RK_CMPBUF;
                    sel.ch   = CH_IDX_W'(n);
                end
                if (word == WW'(5 + 3 * n)) begin
                    sel.kind = RK_LIVE;
                    sel.ch   = CH_IDX_W'(n);
                end
            end
            if (word == WW'(3 + 3 * CMP_CH)) begin
                sel.kind = RK_CNTBUF;
                sel.ch   = CH_IDX_W'(CMP_CH);
            end
            if (word == WW'(4 + 3 * CMP_CH)) begin
                sel.kind = RK_LIVE;
                sel.ch   = CH_IDX_W'(CMP_CH);
            end
        end
    end

endmodule

// File: rtl/rtb_channel.sv
// One down-counter channel. A load copies the buffer and takes priority over
// a tick in the same cycle. A tick while running decrements; a tick at zero
// is an expiry, which reloads when reload_en is set and otherwise holds zero.
// Assumes the parent removes 'run' after a non-reloading expiry.
module rtb_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] buf_val,
    output logic [CNT_W-1:0] count,
    output logic             hit,
    output logic             evt
);

    logic [CNT_W-1:0] count_q;
    logic             evt_q;

    assign hit   = run && tick && !load && (count_q == '0);
    assign count = count_q;
    assign evt   = evt_q;

    // Counter update: load, decrement, or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= buf_val;
        end else if (run && tick) begin
            if (count_q == '0) begin
                if (reload_en) count_q <= buf_val;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // Expiry event register: one pulse per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= hit;
    end

    AST_LOAD_TAKES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_q == $past(buf_val)); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count_q)); // R5

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R6

endmodule

// File: rtl/rtb_ctl_edge.sv
// Control-word edge logic for one channel: detects a rising manual-load bit
// between the stored and the incoming word, and flags a non-reloading expiry
// that must clear the stored start bit. Assumes compile-time bit positions.
module rtb_ctl_edge #(
    parameter int DATA_W   = 32,
    parameter int LOAD_BIT = 1,
    parameter int RLD_BIT  = 3
) (
    input  logic [DATA_W-1:0] ctl_q,
    input  logic [DATA_W-1:0] ctl_new,
    input  logic              ctl_wr,
    input  logic              hit,
    output logic              load,
    output logic              clr_start
);

    // Manual load on a 0-to-1 change of the load bit.
    always_comb load = ctl_wr && ctl_new[LOAD_BIT] && !ctl_q[LOAD_BIT];

    // Stop request on an expiry without auto-reload.
    always_comb clr_start = hit && !ctl_q[RLD_BIT];

endmodule

// File: rtl/reload_timer_bank.sv
// Five-channel buffered down-counter bank with a word-addressed register
// file. Holds the configuration words, the shared control word and the
// per-channel buffers; instantiates one counter per channel. Reads are
// combinational from the address. Assumes DATA_W >= 23 and CNT_W <= DATA_W.
module reload_timer_bank
    import rtb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic [NUM_CH-1:0] expire_evt,
    output logic [CMP_CH-1:0] inv_sel,
    output logic [DATA_W-1:0] presc_cfg,
    output logic [DATA_W-1:0] div_cfg
);

    localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'(ctl_mask());

    reg_sel_t          sel;
    logic [DATA_W-1:0] presc_q;
    logic [DATA_W-1:0] div_q;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] ctl_d;
    logic [DATA_W-1:0] ctl_new;
    logic              ctl_wr;
    logic [CNT_W-1:0]  cnt_buf [NUM_CH];
    logic [CNT_W-1:0]  cmp_buf [CMP_CH];
    logic [CNT_W-1:0]  cnt     [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] load;
    logic [NUM_CH-1:0] clr_start;

    rtb_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign ctl_wr    = bus_wr && (sel.kind == RK_CTL);
    assign ctl_new   = bus_wdata & CTL_MASK;
    assign presc_cfg = presc_q;
    assign div_cfg   = div_q;

    // Configuration word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            div_q   <= '0;
        end else if (bus_wr) begin
            if (sel.kind == RK_PRESC) presc_q <= bus_wdata;
            if (sel.kind == RK_DIV)   div_q   <= bus_wdata;
        end
    end

    // Next control word: hardware start clears, overridden by a bus write.
    always_comb begin
        ctl_d = ctl_q;
        for (int unsigned n = 0; n < NUM_CH; n++) begin
            if (clr_start[n]) ctl_d[start_pos(n)] = 1'b0;
        end
        if (ctl_wr) ctl_d = ctl_new;
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Count and compare buffer storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_CH; n++) cnt_buf[n] <= '0;
            for (int n = 0; n < CMP_CH; n++) cmp_buf[n] <= '0;
        end else if (bus_wr) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (sel.kind == RK_CNTBUF && sel.ch == CH_IDX_W'(n))
                    cnt_buf[n] <= bus_wdata[CNT_W-1:0];
            end
            for (int n = 0; n < CMP_CH; n++) begin
                if (sel.kind == RK_CMPBUF && sel.ch == CH_IDX_W'(n))
                    cmp_buf[n] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            RK_PRESC: bus_rdata = presc_q;
            RK_DIV:   bus_rdata = div_q;
            RK_CTL:   bus_rdata = ctl_q;
            default:  bus_rdata = '0;
        endcase
        for (int n = 0; n < NUM_CH; n++) begin
            if (sel.ch == CH_IDX_W'(n)) begin
                if (sel.kind == RK_CNTBUF) bus_rdata = DATA_W'(cnt_buf[n]);
                if (sel.kind == RK_LIVE)   bus_rdata = DATA_W'(cnt[n]);
            end
        end
        for (int n = 0; n < CMP_CH; n++) begin
            if (sel.ch == CH_IDX_W'(n) && sel.kind == RK_CMPBUF)
                bus_rdata = DATA_W'(cmp_buf[n]);
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
        localparam int SB = int'(start_pos(g));
        localparam int LB = int'(load_pos(g));
        localparam int RB = int'(rld_pos(g));

        rtb_ctl_edge #(
            .DATA_W   (DATA_W),
            .LOAD_BIT (LB),
            .RLD_BIT  (RB)
        ) u_edge (
            .ctl_q     (ctl_q),
            .ctl_new   (ctl_new),
            .ctl_wr    (ctl_wr),
            .hit       (hit[g]),
            .load      (load[g]),
            .clr_start (clr_start[g])
        );

        rtb_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_en[g]),
            .run       (ctl_q[SB]),
            .load      (load[g]),
            .reload_en (ctl_q[RB]),
            .buf_val   (cnt_buf[g]),
            .count     (cnt[g]),
            .hit       (hit[g]),
            .evt       (expire_evt[g])
        );

        AST_EVT_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            expire_evt[g] |-> $past(cnt[g]) == '0); // R7

        AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && !ctl_q[RB] && !ctl_wr) |=> !ctl_q[SB]); // R8

        AST_RELOAD_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && ctl_q[RB] && !ctl_wr) |=> ctl_q[SB] && cnt[g] == $past(cnt_buf[g])); // R8
    end

    for (genvar g = 0; g < CMP_CH; g++) begin : gen_inv
        assign inv_sel[g] = ctl_q[inv_pos(g)];
    end

    AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTL_MASK) == '0); // R2

endmodule

// File: tb/sim_reload_timer_bank.sv
module sim_reload_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_en = '0;
    logic [4:0]  expire_evt;
    logic [3:0]  inv_sel;
    logic [31:0] presc_cfg;
    logic [31:0] div_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    reload_timer_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tick_en    (tick_en),
        .expire_evt (expire_evt),
        .inv_sel    (inv_sel),
        .presc_cfg  (presc_cfg),
        .div_cfg    (div_cfg)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic test_reset();
        rd_chk("R1 presc", 8'h00, 32'h0);
        rd_chk("R1 ctl", 8'h08, 32'h0);
        rd_chk("R1 buf0", 8'h0C, 32'h0);
        rd_chk("R1 live4", 8'h40, 32'h0);
        check("R1 evt", 32'(expire_evt), 32'h0);
    endtask

    task automatic test_map();
        wr(8'h00, 32'h12345678);
        wr(8'h04, 32'h00000321);
        rd_chk("R2 presc", 8'h00, 32'h12345678);
        rd_chk("R2 div", 8'h04, 32'h00000321);
        check("R12 presc_cfg", presc_cfg, 32'h12345678);
        check("R12 div_cfg", div_cfg, 32'h00000321);
        wr(8'h34, 32'h0000ABCD);
        rd_chk("R2 cmp3", 8'h34, 32'h0000ABCD);
        wr(8'h0C, 32'h55);
        wr(8'h0D, 32'h99);
        rd_chk("R10 misaligned write ignored", 8'h0C, 32'h55);
        rd_chk("R10 misaligned read", 8'h0D, 32'h0);
        wr(8'h44, 32'hFFFFFFFF);
        rd_chk("R10 0x44 reads 0", 8'h44, 32'h0);
        wr(8'h48, 32'h1);
        rd_chk("R10 0x48 reads 0", 8'h48, 32'h0);
        rd_chk("R9 no cmp for ch4 at 0x44", 8'h44, 32'h0);
        wr(8'h08, 32'hFFFFFFFF);
        rd_chk("R2 ctl mask", 8'h08, 32'h007FFF0F);
        check("R3 inv all", 32'(inv_sel), 32'hF);
        wr(8'h08, 32'h0);
    endtask

    task automatic test_layout();
        wr(8'h08, (32'h1 << 10) | (32'h1 << 18));
        check("R3 inv ch1 ch3", 32'(inv_sel), 32'hA);
        wr(8'h08, 32'h0);
    endtask

    task automatic test_load();
        wr(8'h0C, 32'd7);
        wr(8'h08, 32'h2);
        rd_chk("R4 load", 8'h14, 32'd7);
        wr(8'h0C, 32'd9);
        wr(8'h08, 32'h2);
        rd_chk("R4 no reload when bit held", 8'h14, 32'd7);
        wr(8'h08, 32'h0);
        wr(8'h08, 32'h2);
        rd_chk("R4 reload after rearm", 8'h14, 32'd9);
        wr(8'h08, 32'h0);
    endtask

    task automatic test_simul();
        wr(8'h0C, 32'd4);
        tick_en = 5'b00001;
        wr(8'h08, 32'h3);
        rd_chk("R11 load before decrement", 8'h14, 32'd4);
        @(negedge clk);
        rd_chk("R11 first decrement", 8'h14, 32'd3);
        tick_en = '0;
        wr(8'h08, 32'h0);
    endtask

    task automatic test_count();
        logic [31:0] ch0;
        bus_addr = 8'h14; #1; ch0 = bus_rdata;
        wr(8'h24, 32'd10);
        wr(8'h08, 32'h3000);
        tick_en = 5'b00100;
        repeat (4) @(negedge clk);
        tick_en = '0;
        rd_chk("R6 ch2 after 4 ticks", 8'h2C, 32'd6);
        rd_chk("R6 ch0 untouched", 8'h14, ch0);
        wr(8'h08, 32'h0);
        tick_en = 5'b00100;
        repeat (3) @(negedge clk);
        tick_en = '0;
        rd_chk("R5 stopped holds", 8'h2C, 32'd6);
        wr(8'h08, 32'h1000);
        tick_en = 5'b00100;
        repeat (2) @(negedge clk);
        tick_en = '0;
        rd_chk("R5 restart from held value", 8'h2C, 32'd4);
        wr(8'h08, 32'h0);
    endtask

    task automatic test_expire_stop();
        wr(8'h0C, 32'd2);
        wr(8'h08, 32'h3);
        tick_en = 5'b00001;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R6 reached zero", 8'h14, 32'd0);
        check("R7 no event at zero", 32'(expire_evt), 32'h0);
        @(negedge clk);
        check("R7 event after zero tick", 32'(expire_evt), 32'h1);
        tick_en = '0;
        rd_chk("R8 stays zero", 8'h14, 32'd0);
        rd_chk("R8 start cleared", 8'h08, 32'h2);
        @(negedge clk);
        check("R7 event one cycle", 32'(expire_evt), 32'h0);
        tick_en = 5'b00001;
        repeat (2) @(negedge clk);
        tick_en = '0;
        check("R8 stopped no event", 32'(expire_evt), 32'h0);
        rd_chk("R8 stopped count", 8'h14, 32'd0);
        wr(8'h08, 32'h0);
    endtask

    task automatic test_expire_reload();
        wr(8'h0C, 32'd2);
        wr(8'h08, 32'hB);
        tick_en = 5'b00001;
        repeat (3) @(negedge clk);
        check("R7 reload event", 32'(expire_evt), 32'h1);
        rd_chk("R8 reloaded", 8'h14, 32'd2);
        rd_chk("R8 start kept", 8'h08, 32'hB);
        @(negedge clk);
        tick_en = '0;
        rd_chk("R8 keeps running", 8'h14, 32'd1);
        check("R7 event dropped", 32'(expire_evt), 32'h0);
        wr(8'h08, 32'h0);
    endtask

    task automatic test_ch4();
        wr(8'h3C, 32'd1);
        rd_chk("R9 ch4 buffer", 8'h3C, 32'd1);
        wr(8'h08, 32'h00700000);
        rd_chk("R9 ch4 load", 8'h40, 32'd1);
        tick_en = 5'b10000;
        repeat (2) @(negedge clk);
        tick_en = '0;
        check("R9 ch4 event", 32'(expire_evt), 32'h10);
        rd_chk("R9 ch4 reload via bit 22", 8'h40, 32'd1);
        rd_chk("R9 ch4 start kept", 8'h08, 32'h00700000);
        wr(8'h08, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_map();
        test_layout();
        test_load();
        test_simul();
        test_count();
        test_expire_stop();
        test_expire_reload();
        test_ch4();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule